// File: doc/BRIEF.md
# Binary/BCD Add-Subtract Unit

This block is the arithmetic slice of an 8-bit processor's ALU. It adds with carry or subtracts with borrow. A decimal-mode input selects plain binary or packed-BCD arithmetic. The surrounding datapath presents the accumulator, the operand, the incoming carry, the operation select and the decimal flag together with a one-cycle `in_valid` strobe. One clock edge later the block holds the result and the four status flags (carry, overflow, zero, negative) in registers and raises `out_done` for one cycle.

The decimal-mode flags copy the behaviour of an older processor family, and legacy software relies on it. After a BCD add, zero reflects the plain binary sum. Negative and overflow are taken from the high digit before its decimal correction. After a BCD subtract, every flag reflects the plain binary difference and only the result byte gets the decimal correction.

A two-state machine controls the block. In `ST_IDLE` no result is new. In `ST_DONE` the registers were loaded on the previous edge. Each transition is named:
- `T_LAUNCH` goes from `ST_IDLE` to `ST_DONE` on `in_valid`.
- `T_CHAIN` stays in `ST_DONE` on a back-to-back `in_valid`.
- `T_RETIRE` goes from `ST_DONE` to `ST_IDLE` when no strobe arrives.
- `T_WAIT` stays in `ST_IDLE` when no strobe arrives.

Top module: `addsub_bcd_unit`

## Requirements
- R1: After reset, `out_done`, `out_result` and all four flags are 0.
- R2: `out_done` is 1 in exactly the cycle after each cycle in which `in_valid` was 1, and 0 otherwise.
- R3: Binary add (`op_sub`=0, `dec_mode`=0): the 9-bit value A+B+C gives `out_result` in its low 8 bits and `out_carry` in bit 8. Zero is set when the 8-bit result is 0. Negative is result bit 7.
- R4: Binary add overflow is 1 when A[7]==B[7] and result bit 7 differs from A[7].
- R5: Decimal add: lo = A[3:0]+B[3:0]+C, plus 6 when lo>9. hi = A[7:4]+B[7:4], plus 1 when the adjusted lo>15. Then hi gets +6 when hi>9. `out_carry` = (final hi>15). `out_result` = {final hi[3:0], lo[3:0]}.
- R6: Decimal add zero is set when (A+B+C) mod 256 is 0. Negative is bit 3 of hi before its +6 correction.
- R7: Decimal add overflow is 1 when A[7]==B[7] and bit 3 of the uncorrected hi differs from A[7].
- R8: Subtract: D = A-B-(1-C). `out_carry` is 1 when D does not go below zero. Zero and negative come from D mod 256. In binary mode `out_result` = D mod 256.
- R9: Subtract overflow (both modes) is 1 when A[7]!=B[7] and bit 7 of D mod 256 differs from A[7].
- R10: Decimal subtract: lo = A[3:0]-B[3:0]-(1-C) and hi = A[7:4]-B[7:4]. If lo is negative, lo -= 6 and hi -= 1. Then if hi is negative, hi -= 6. `out_result` = {hi mod 16, lo mod 16}. The flags follow R8 and R9 unchanged.
- R11: In a cycle without `in_valid`, the result and flag outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one cycle per operation |
| op_sub | input | 1 | 1 = subtract with borrow, 0 = add with carry |
| dec_mode | input | 1 | 1 = packed-BCD arithmetic |
| acc_in | input | 8 | Accumulator operand A |
| opnd_in | input | 8 | Second operand B |
| carry_in | input | 1 | Incoming carry C (for subtract, 1 means no borrow) |
| out_done | output | 1 | Result-ready pulse |
| out_result | output | 8 | Registered result byte |
| out_carry | output | 1 | Registered carry flag |
| out_ovf | output | 1 | Registered overflow flag |
| out_zero | output | 1 | Registered zero flag |
| out_neg | output | 1 | Registered negative flag |

## Verification
The hardest case to reach is a decimal add in which the decimal result and the flags disagree. For example, 0x50+0x50 gives a result of 0x00 with carry, but zero stays clear while negative and overflow are set. Another case is a sum whose binary value wraps to zero while its BCD value does not. Random operands almost never produce these cases together, so the stimulus adds directed vectors for them:
- a cascade through both digit corrections;
- binary wrap to zero;
- a decimal borrow out of 0x00.

Random operations around these vectors reach every mode combination, including back-to-back strobes and idle gaps.

// File: rtl/addsub_bcd_pkg.sv
package addsub_bcd_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int MSB = DW - 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } unit_state_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          c;
        logic          v;
        logic          z;
        logic          n;
    } alu_out_t;
endpackage

// File: rtl/addsub_bin_core.sv
module addsub_bin_core
    import addsub_bcd_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  logic          sub,
    output alu_out_t      o
);
    logic [DW:0] ext;

    always_comb begin
        if (sub)
            ext = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ~cin};
        else
            ext = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        o.res = ext[DW-1:0];
        o.c   = sub ? ~ext[DW] : ext[DW];
        o.z   = (ext[DW-1:0] == '0);
        o.n   = ext[MSB];
        if (sub)
            o.v = (a[MSB] ^ b[MSB]) & (a[MSB] ^ ext[MSB]);
        else
            o.v = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ ext[MSB]);
    end
endmodule

// File: rtl/bcd_add_fix.sv
module bcd_add_fix
    import addsub_bcd_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          c,
    output logic          v,
    output logic          n
);
    logic [NW+1:0] lo;
    logic [NW+1:0] hi_raw;
    logic [NW+1:0] hi_fix;

    always_comb begin
        lo = {2'b00, a[NW-1:0]} + {2'b00, b[NW-1:0]} + {{(NW+1){1'b0}}, cin};
        if (lo > 6'd9)
            lo = lo + 6'd6;
        hi_raw = {2'b00, a[DW-1:NW]} + {2'b00, b[DW-1:NW]}
                 + {{(NW+1){1'b0}}, (lo > 6'd15)};
        n = hi_raw[NW-1];
        v = (hi_raw[NW-1] ^ a[MSB]) & ~(a[MSB] ^ b[MSB]);
        hi_fix = (hi_raw > 6'd9) ? hi_raw + 6'd6 : hi_raw;
        c   = (hi_fix > 6'd15);
        res = {hi_fix[NW-1:0], lo[NW-1:0]};
    end
endmodule

// File: rtl/bcd_sub_fix.sv
module bcd_sub_fix
    import addsub_bcd_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res
);
    logic [NW:0] lo;
    logic [NW:0] hi;

    always_comb begin
        lo = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, ~cin};
        hi = {1'b0, a[DW-1:NW]} - {1'b0, b[DW-1:NW]};
        if (lo[NW]) begin
            lo = lo - 5'd6;
            hi = hi - 5'd1;
        end
        if (hi[NW])
            hi = hi - 5'd6;
        res = {hi[NW-1:0], lo[NW-1:0]};
    end
endmodule

// File: rtl/addsub_bcd_unit.sv
module addsub_bcd_unit
    import addsub_bcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          op_sub,
    input  logic          dec_mode,
    input  logic [7:0]    acc_in,
    input  logic [7:0]    opnd_in,
    input  logic          carry_in,
    output logic          out_done,
    output logic [7:0]    out_result,
    output logic          out_carry,
    output logic          out_ovf,
    output logic          out_zero,
    output logic          out_neg
);
    unit_state_t st_q, st_d;
    alu_out_t    bin_o, sel_o, reg_q;
    logic [DW-1:0] dadd_res, dsub_res;
    logic          dadd_c, dadd_v, dadd_n;

    addsub_bin_core u_bin (
        .a(acc_in), .b(opnd_in), .cin(carry_in), .sub(op_sub), .o(bin_o)
    );

    bcd_add_fix u_dadd (
        .a(acc_in), .b(opnd_in), .cin(carry_in),
        .res(dadd_res), .c(dadd_c), .v(dadd_v), .n(dadd_n)
    );

    bcd_sub_fix u_dsub (
        .a(acc_in), .b(opnd_in), .cin(carry_in), .res(dsub_res)
    );

    // Mode select: decimal add keeps only zero from the binary core
    always_comb begin
        sel_o = bin_o;
        if (dec_mode && !op_sub) begin
            sel_o.res = dadd_res;
            sel_o.c   = dadd_c;
            sel_o.v   = dadd_v;
            sel_o.n   = dadd_n;
        end else if (dec_mode && op_sub) begin
            sel_o.res = dsub_res;
        end
    end

    // Next-state logic: T_LAUNCH, T_CHAIN, T_RETIRE, T_WAIT
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: st_d = in_valid ? ST_DONE : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        reg_q <= '0;
        else if (in_valid) reg_q <= sel_o;
    end

    assign out_done   = (st_q == ST_DONE);
    assign out_result = reg_q.res;
    assign out_carry  = reg_q.c;
    assign out_ovf    = reg_q.v;
    assign out_zero   = reg_q.z;
    assign out_neg    = reg_q.n;
endmodule

// File: rtl/addsub_bcd_chk.sv
module addsub_bcd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       op_sub,
    input logic       dec_mode,
    input logic [7:0] acc_in,
    input logic [7:0] opnd_in,
    input logic       carry_in,
    input logic       out_done,
    input logic [7:0] out_result,
    input logic       out_carry,
    input logic       out_ovf,
    input logic       out_zero,
    input logic       out_neg
);
    logic [8:0] p_sum;
    logic [8:0] p_dif;
    assign p_sum = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, carry_in};
    assign p_dif = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, ~carry_in};

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_done && out_result == 8'd0));

    assert_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    assert_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);

    assert_bin_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sub && !dec_mode) |=> ({out_carry, out_result} == $past(p_sum)));

    assert_dec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sub && dec_mode) |=> (out_zero == ($past(p_sum[7:0]) == 8'd0)));

    assert_sub_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sub) |=> (out_carry == !$past(p_dif[8])));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_carry) && $stable(out_ovf)
                       && $stable(out_zero) && $stable(out_neg)));
endmodule

bind addsub_bcd_unit addsub_bcd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
    .out_done(out_done), .out_result(out_result), .out_carry(out_carry),
    .out_ovf(out_ovf), .out_zero(out_zero), .out_neg(out_neg)
);

// File: tb/sim_addsub_bcd_unit.sv
module sim_addsub_bcd_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       op_sub = 1'b0;
    logic       dec_mode = 1'b0;
    logic [7:0] acc_in = 8'd0;
    logic [7:0] opnd_in = 8'd0;
    logic       carry_in = 1'b0;
    logic       out_done;
    logic [7:0] out_result;
    logic       out_carry, out_ovf, out_zero, out_neg;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addsub_bcd_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .dec_mode(dec_mode), .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in),
        .out_done(out_done), .out_result(out_result), .out_carry(out_carry),
        .out_ovf(out_ovf), .out_zero(out_zero), .out_neg(out_neg)
    );

    // Expected {result, c, v, z, n} from the requirement text
    function automatic logic [11:0] model(input int a, input int b, input int c,
                                          input bit sub, input bit dec);
        int r, cf, vf, zf, nf, lo, hi, d;
        if (!sub) begin
            r  = a + b + c;
            zf = ((r % 256) == 0);
            if (!dec) begin                       // R3, R4
                cf = (r > 255);
                nf = (r / 128) % 2;
                vf = ((a / 128) == (b / 128)) && (((r % 256) / 128) != (a / 128));
                r  = r % 256;
            end else begin                        // R5, R6, R7
                lo = (a % 16) + (b % 16) + c;
                if (lo > 9) lo = lo + 6;
                hi = (a / 16) + (b / 16) + ((lo > 15) ? 1 : 0);
                nf = (hi / 8) % 2;
                vf = ((a / 128) == (b / 128)) && (nf != (a / 128));
                if (hi > 9) hi = hi + 6;
                cf = (hi > 15);
                r  = (hi % 16) * 16 + (lo % 16);
            end
        end else begin                            // R8, R9, R10
            d  = a - b - (1 - c);
            cf = (d >= 0);
            r  = (d + 256) % 256;
            zf = (r == 0);
            nf = r / 128;
            vf = ((a / 128) != (b / 128)) && ((r / 128) != (a / 128));
            if (dec) begin
                lo = (a % 16) - (b % 16) - (1 - c);
                hi = (a / 16) - (b / 16);
                if (lo < 0) begin lo = lo - 6; hi = hi - 1; end
                if (hi < 0) hi = hi - 6;
                r = (((hi % 16) + 16) % 16) * 16 + (((lo % 16) + 16) % 16);
            end
        end
        return {r[7:0], cf[0], vf[0], zf[0], nf[0]};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %03h expected %03h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input bit sub, input bit dec);
        if (!sub && !dec) return "R3 R4 binary add";
        if (!sub &&  dec) return "R5 R6 R7 decimal add";
        if ( sub && !dec) return "R8 R9 binary subtract";
        return "R10 decimal subtract";
    endfunction

    task automatic do_op(input logic [7:0] a, input logic [7:0] b, input bit c,
                         input bit sub, input bit dec);
        acc_in = a; opnd_in = b; carry_in = c; op_sub = sub; dec_mode = dec;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 done pulse", {11'd0, out_done}, 12'd1);
        check(tag_of(sub, dec),
              {out_result, out_carry, out_ovf, out_zero, out_neg},
              model(a, b, c, sub, dec));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        check("R1 reset state", {out_result, out_carry, out_ovf, out_zero, out_neg, out_done} == 13'd0 ? 12'd0 : 12'd1, 12'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        do_op(8'h99, 8'h01, 1'b0, 1'b0, 1'b1);   // R5 cascade to 0x00 carry
        do_op(8'h50, 8'h50, 1'b0, 1'b0, 1'b1);   // R6 R7 flag quirks
        do_op(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);   // R4 overflow
        do_op(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);   // R3 wrap to zero
        do_op(8'h00, 8'h01, 1'b1, 1'b1, 1'b1);   // R10 borrow to 0x99
        do_op(8'h80, 8'h01, 1'b1, 1'b1, 1'b0);   // R9 overflow
        do_op(8'h9A, 8'h66, 1'b0, 1'b0, 1'b1);   // R6 binary sum zero, decimal not

        // R11: idle cycle keeps outputs, done drops
        held = {out_result, out_carry, out_ovf, out_zero, out_neg};
        acc_in = 8'h12; opnd_in = 8'h34;
        @(negedge clk);
        check("R11 hold", {out_result, out_carry, out_ovf, out_zero, out_neg}, held);
        check("R2 no done when idle", {11'd0, out_done}, 12'd0);

        // Random mix, back-to-back and with gaps
        for (int i = 0; i < 600; i++) begin
            do_op(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 4 == 0) begin
                held = {out_result, out_carry, out_ovf, out_zero, out_neg};
                @(negedge clk);
                check("R11 hold random", {out_result, out_carry, out_ovf, out_zero, out_neg}, held);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule